// File: doc/BRIEF.md
# Mixed-Sign Fractional Multiplier

This block multiplies two 16-bit operands in one clock. Each operand carries its own signedness select, which widens it to 17 bits with either a copy of its top bit or a zero. So one 17 x 17 signed product covers signed x signed, unsigned x unsigned and either mixed pairing. A mode input picks integer results or 1.15 fractional results. In fractional mode the product is doubled so that it lands in 1.31 alignment. The 34-bit signed output is wide enough that full-scale negative times full-scale negative gives exactly +1.0 (0x0_8000_0000) instead of wrapping to a negative value.

A caller presents both operands, the two selects and the mode, then pulses the strobe for one cycle. On the next rising edge the result and a valid flag are registered. A two-state controller tracks whether the output register holds a fresh result:

- `ST_EMPTY` (valid low) moves to `ST_FULL` on a strobe and stays in `ST_EMPTY` otherwise.
- `ST_FULL` (valid high) stays in `ST_FULL` on a further strobe and returns to `ST_EMPTY` without one.

Accumulation, saturation and rounding belong to the consumer.

Top module: `mfm_top`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released, prod_o is zero and vld_o is low until the first strobe.
- R2: An operand whose select is 1 is read as two's complement (bit 16 copies bit 15). An operand whose select is 0 is read as an unsigned magnitude (bit 16 is zero). The two selects act independently.
- R3: With frac_i = 0, prod_o equals the exact product of the two widened operands as a 34-bit signed value.
- R4: With frac_i = 1, prod_o equals the low 34 bits of twice the product (1.31 alignment for 1.15 inputs).
- R5: With frac_i = 1, both selects 1 and both operands 0x8000, prod_o is 34'h0_8000_0000, with bit 33 clear.
- R6: vld_o is high in the cycle after a cycle with go_i high, and low in the cycle after a cycle with go_i low.
- R7: prod_o keeps its value across any cycle in which go_i is low.
- R8: Strobes on consecutive cycles produce results on consecutive cycles, in strobe order.
- R9: With frac_i = 0 and both selects 0, prod_o is never negative; 0xFFFF x 0xFFFF gives 0x0_FFFE_0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Strobe: capture a product this cycle |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| a_sgn_i | input | 1 | 1: a_i is signed, 0: unsigned |
| b_sgn_i | input | 1 | 1: b_i is signed, 0: unsigned |
| frac_i | input | 1 | 1: fractional 1.15 mode, 0: integer mode |
| prod_o | output | 34 | Registered signed product |
| vld_o | output | 1 | Result captured on the previous edge |

## Verification
The assertions assume that the operands, selects and mode are settled before the edge on which go_i is high. They also assume go_i is a plain level that is sampled each cycle, with no handshake behind it. The bench changes inputs only on the falling edge and holds go_i for exactly one cycle per operation, or for a run of cycles in the back-to-back case. Between strobes it varies the operands while go_i stays low, so the checks that the held output is unaffected do more than pass trivially.

// File: rtl/mfm_pkg.sv
package mfm_pkg;
    localparam int OP_W   = 16;
    localparam int EXT_W  = OP_W + 1;
    localparam int PROD_W = 2 * EXT_W;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } mfm_state_e;
endpackage

// File: rtl/mfm_extend.sv
module mfm_extend #(
    parameter int OP_W = 16,
    localparam int EXT_W = OP_W + 1
) (
    input  logic [OP_W-1:0]         op_i,
    input  logic                    sgn_i,
    output logic signed [EXT_W-1:0] ext_o
);
    // Top bit either replicates the operand sign or is forced to zero.
    always_comb begin
        ext_o = {(sgn_i & op_i[OP_W-1]), op_i};
    end
endmodule

// File: rtl/mfm_core.sv
module mfm_core #(
    parameter int EXT_W = 17,
    localparam int PROD_W = 2 * EXT_W
) (
    input  logic signed [EXT_W-1:0]  x_i,
    input  logic signed [EXT_W-1:0]  y_i,
    input  logic                     frac_i,
    output logic signed [PROD_W-1:0] p_o
);
    logic signed [PROD_W-1:0] raw;

    always_comb begin
        raw = x_i * y_i;
        if (frac_i) begin
            p_o = raw <<< 1;
        end else begin
            p_o = raw;
        end
    end
endmodule

// File: rtl/mfm_top.sv
module mfm_top
    import mfm_pkg::*;
#(
    parameter int A_W = OP_W,
    localparam int X_W = A_W + 1,
    localparam int P_W = 2 * X_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go_i,
    input  logic [A_W-1:0] a_i,
    input  logic [A_W-1:0] b_i,
    input  logic           a_sgn_i,
    input  logic           b_sgn_i,
    input  logic           frac_i,
    output logic [P_W-1:0] prod_o,
    output logic           vld_o
);
    mfm_state_e state_q, state_d;

    logic [1:0][A_W-1:0]     op_arr;
    logic [1:0]              sgn_arr;
    logic signed [X_W-1:0]   ext_arr [2];
    logic signed [P_W-1:0]   prod_d;

    assign op_arr  = {b_i, a_i};
    assign sgn_arr = {b_sgn_i, a_sgn_i};

    for (genvar gi = 0; gi < 2; gi++) begin : g_ext
        mfm_extend #(.OP_W(A_W)) ext_i (
            .op_i  (op_arr[gi]),
            .sgn_i (sgn_arr[gi]),
            .ext_o (ext_arr[gi])
        );
    end

    mfm_core #(.EXT_W(X_W)) core_i (
        .x_i    (ext_arr[0]),
        .y_i    (ext_arr[1]),
        .frac_i (frac_i),
        .p_o    (prod_d)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = go_i ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = go_i ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_o <= '0;
        end else if (go_i) begin
            prod_o <= prod_d;
        end
    end

    always_comb begin
        vld_o = (state_q == ST_FULL);
    end
endmodule

// File: rtl/mfm_chk.sv
module mfm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        go_i,
    input logic [15:0] a_i,
    input logic [15:0] b_i,
    input logic        a_sgn_i,
    input logic        b_sgn_i,
    input logic        frac_i,
    input logic [33:0] prod_o,
    input logic        vld_o
);
    // R6
    vld_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |=> vld_o);

    // R6
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> !vld_o);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> $stable(prod_o));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && frac_i && a_sgn_i && b_sgn_i && a_i == 16'h8000 && b_i == 16'h8000)
        |=> (prod_o == 34'h0_8000_0000));

    // R9
    uns_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !frac_i && !a_sgn_i && !b_sgn_i) |=> !prod_o[33]);

    // R3
    zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && (a_i == 16'h0 || b_i == 16'h0)) |=> (prod_o == 34'h0));
endmodule

bind mfm_top mfm_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (go_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .a_sgn_i (a_sgn_i),
    .b_sgn_i (b_sgn_i),
    .frac_i  (frac_i),
    .prod_o  (prod_o),
    .vld_o   (vld_o)
);

// File: tb/mfm_top_tb.sv
module mfm_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go_i = 1'b0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic        a_sgn_i = 1'b0;
    logic        b_sgn_i = 1'b0;
    logic        frac_i = 1'b0;
    logic [33:0] prod_o;
    logic        vld_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [33:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    mfm_top dut_i (
        .clk(clk), .rst_n(rst_n), .go_i(go_i), .a_i(a_i), .b_i(b_i),
        .a_sgn_i(a_sgn_i), .b_sgn_i(b_sgn_i), .frac_i(frac_i),
        .prod_o(prod_o), .vld_o(vld_o)
    );

    function automatic logic [33:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input bit as, input bit bs, input bit fr);
        longint x, y, p;
        x = as ? longint'($signed(a)) : longint'(a);
        y = bs ? longint'($signed(b)) : longint'(b);
        p = x * y;
        if (fr) p = p * 2;
        return p[33:0];
    endfunction

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Driver: one operation per call, pushes the expected item.
    task automatic send(input string tag, input logic [15:0] a, input logic [15:0] b,
                        input bit as, input bit bs, input bit fr, input bit keep);
        item_t it;
        @(negedge clk);
        a_i = a; b_i = b; a_sgn_i = as; b_sgn_i = bs; frac_i = fr; go_i = 1'b1;
        it.exp = model(a, b, as, bs, fr);
        it.tag = tag;
        sb.push_back(it);
        if (!keep) begin
            @(negedge clk);
            go_i = 1'b0;
            a_i = ~a; b_i = b ^ 16'h5A5A;
        end
    endtask

    // Monitor: compare each valid result against the queue head.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && vld_o) begin
                if (sb.size() == 0) begin
                    check("R6_spurious_vld", 34'h1, 34'h0);
                end else begin
                    it = sb.pop_front();
                    check(it.tag, prod_o, it.exp);
                end
            end
        end
    end

    initial begin
        logic [33:0] held;
        #1;
        check("R1_reset_prod", prod_o, 34'h0);
        check("R1_reset_vld", {33'h0, vld_o}, 34'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1_after_release_vld", {33'h0, vld_o}, 34'h0);

        send("R3_int_ss", 16'd1234, 16'hFF85, 1, 1, 0, 0);
        send("R3_int_uu", 16'd300, 16'd7, 0, 0, 0, 0);
        send("R9_int_uu_max", 16'hFFFF, 16'hFFFF, 0, 0, 0, 0);
        send("R2_int_ss_ffff", 16'hFFFF, 16'hFFFF, 1, 1, 0, 0);
        send("R2_int_su", 16'hFFFF, 16'hFFFF, 1, 0, 0, 0);
        send("R2_int_us", 16'h8000, 16'h8000, 0, 1, 0, 0);
        send("R3_int_ss_min", 16'h8000, 16'h8000, 1, 1, 0, 0);
        send("R5_frac_minus1_sq", 16'h8000, 16'h8000, 1, 1, 1, 0);
        send("R4_frac_half", 16'h4000, 16'h4000, 1, 1, 1, 0);
        send("R4_frac_neg", 16'h8000, 16'h7FFF, 1, 1, 1, 0);
        send("R4_frac_mixed", 16'hFFFF, 16'h8000, 0, 1, 1, 0);
        send("R4_frac_uu_wrap", 16'hFFFF, 16'hFFFF, 0, 0, 1, 0);
        send("R3_zero", 16'h0000, 16'h8000, 1, 1, 0, 0);

        // R7: output held while strobe is low and inputs move
        @(negedge clk);
        held = prod_o;
        a_i = 16'h1357; b_i = 16'h2468; frac_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R7_hold", prod_o, held);
        check("R6_vld_low_idle", {33'h0, vld_o}, 34'h0);

        // R8: back-to-back strobes
        send("R8_b2b_0", 16'd11, 16'd13, 0, 0, 0, 1);
        send("R8_b2b_1", 16'hFFFE, 16'd3, 1, 0, 0, 1);
        send("R8_b2b_2", 16'h7FFF, 16'h7FFF, 1, 1, 1, 1);
        @(negedge clk);
        go_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R8_queue_drained", 34'(sb.size()), 34'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule